// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM from reset to a usable state. Once reset is released it keeps the command pins at NOP for a stabilization pause, with clock enable and the data mask held high. The pause is 200 microseconds by default and is converted to clock cycles from the clock-frequency parameter, rounding up. After the pause the block issues, in a fixed order:

- a precharge of all banks;
- a mode register set that carries a programmable mode word;
- a run of auto-refresh commands.

Each command is followed by its own minimum gap, and NOP fills every gap.

When the last refresh gap has elapsed, the block raises `done` and keeps it high. From then on it drives only NOP, so a memory controller can take over the pins. Command outputs are decoded without a register stage from a single state register and a single countdown counter.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high, the command pins {cs_n,ras_n,cas_n,we_n} show NOP (4'b0111), `addr` is zero, `done` is low, and `cke` and every `dqm` bit are high.
- R2: Let k be the number of rising clock edges seen since `rst` went low. For every k below PAUSE_CYC = ceil(PAUSE_NS*CLK_MHZ/1000), the command is NOP. With the defaults, PAUSE_CYC is 40000, and with PAUSE_NS=1001 at 200 MHz it is 201.
- R3: At k = PAUSE_CYC the block issues precharge-all. The encoding is 4'b0010 with `addr` bit AP_BIT (10) set and every other address bit clear.
- R4: At k = PAUSE_CYC+T_RP the block issues the mode register set. The encoding is 4'b0000 with `addr` equal to MODE_WORD.
- R5: The first auto-refresh comes T_RSC cycles after the mode register set. The encoding is 4'b0001 with `addr` zero.
- R6: Exactly N_REF auto-refreshes are issued, consecutive ones spaced exactly T_RC cycles apart.
- R7: `done` goes high T_RC cycles after the last refresh and then stays high. While `done` is high the command is NOP.
- R8: `cke` and all `dqm` bits are high in every cycle.
- R9: In every cycle that holds none of the commands above, the command is NOP and `addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| dqm | output | DQM_W | Data mask |
| addr | output | ADDR_W | Address bus (mode word or precharge-all bit) |
| done | output | 1 | Initialization complete |

## Verification
The embedded assertions watch every cycle for the following:

- the first command after reset is precharge-all, arriving exactly PAUSE_CYC cycles later;
- each mode register set and refresh follows the correct predecessor at exactly its required gap;
- `done` rises only after N_REF refreshes and the final T_RC gap;
- `done` never drops, and while it is high no command other than NOP appears.

Only the bench scenarios show the address values that go with each command and the rounding up of a pause that is not a whole number of cycles. For these, a second instance with a 1001 ns pause is run against the same cycle-by-cycle model.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int CLK_MHZ   = 200,
  parameter int PAUSE_NS  = 200000,
  parameter int T_RP      = 3,
  parameter int T_RSC     = 2,
  parameter int T_RC      = 9,
  parameter int N_REF     = 8,
  parameter int ADDR_W    = 13,
  parameter int DQM_W     = 2,
  parameter int AP_BIT    = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = 13'h0033
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  localparam int PAUSE_CYC = (PAUSE_NS * CLK_MHZ + 999) / 1000;
  localparam int CW = $clog2(PAUSE_CYC + T_RP + T_RSC + T_RC + 2);
  localparam int RW = $clog2(N_REF + 1);
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_REF = 4'b0001;

  typedef enum logic [1:0] {S_PRE, S_MRS, S_REF, S_END} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [RW-1:0] nref;
  logic [3:0]    cmd;
  logic          fire;

  assign fire = (cnt == '0) && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_PRE;
      cnt  <= CW'(PAUSE_CYC);
      nref <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      unique case (st)
        S_PRE: begin st <= S_MRS; cnt <= CW'(T_RP - 1);  end
        S_MRS: begin st <= S_REF; cnt <= CW'(T_RSC - 1); end
        S_REF: begin
          nref <= nref + 1'b1;
          cnt  <= CW'(T_RC - 1);
          if (nref == RW'(N_REF - 1)) st <= S_END;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cmd  = C_NOP;
    addr = '0;
    if (fire) begin
      unique case (st)
        S_PRE: begin cmd = C_PRE; addr[AP_BIT] = 1'b1; end
        S_MRS: begin cmd = C_MRS; addr = MODE_WORD; end
        S_REF: cmd = C_REF;
        default: ;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke  = 1'b1;
  assign dqm  = '1;
  assign done = fire && (st == S_END);

  logic [3:0]    last_c;
  logic [CW-1:0] gap;
  logic [RW:0]   refs;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_c <= C_NOP;
      gap    <= '0;
      refs   <= '0;
    end else if ({cs_n, ras_n, cas_n, we_n} != C_NOP) begin
      last_c <= {cs_n, ras_n, cas_n, we_n};
      gap    <= CW'(1);
      if ({cs_n, ras_n, cas_n, we_n} == C_REF) refs <= refs + 1'b1;
    end else if (gap != '1) begin
      gap <= gap + 1'b1;
    end
  end

  assert_pause_then_pre_R2: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} != C_NOP && last_c == C_NOP) |->
      ({cs_n, ras_n, cas_n, we_n} == C_PRE && gap == CW'(PAUSE_CYC)));

  assert_mrs_gap_R4: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == C_MRS) |-> (last_c == C_PRE && gap == CW'(T_RP)));

  assert_ref_gap_R6: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == C_REF) |->
      ((last_c == C_MRS && gap == CW'(T_RSC)) || (last_c == C_REF && gap == CW'(T_RC))));

  assert_done_after_refs_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (refs == (RW+1)'(N_REF) && last_c == C_REF && gap == CW'(T_RC)));

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> ({cs_n, ras_n, cas_n, we_n} == C_NOP));

  assert_done_holds_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int T_RP = 3, T_RSC = 2, T_RC = 9, N_REF = 8;
  localparam logic [12:0] MODE = 13'h0032;
  localparam int P_MAIN = 40000;
  localparam int P_CEIL = 201;
  localparam int RUN = P_MAIN + T_RP + T_RSC + N_REF * T_RC + 40;

  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic a_cs, a_ras, a_cas, a_we, a_cke, a_done;
  logic [1:0] a_dqm;
  logic [12:0] a_addr;
  logic b_cs, b_ras, b_cas, b_we, b_cke, b_done;
  logic [1:0] b_dqm;
  logic [12:0] b_addr;

  sdram_init_seq #(.MODE_WORD(MODE)) u_dut (
    .clk(clk), .rst(rst), .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas), .we_n(a_we),
    .cke(a_cke), .dqm(a_dqm), .addr(a_addr), .done(a_done));

  sdram_init_seq #(.PAUSE_NS(1001), .MODE_WORD(MODE)) u_ceil (
    .clk(clk), .rst(rst), .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas), .we_n(b_we),
    .cke(b_cke), .dqm(b_dqm), .addr(b_addr), .done(b_done));

  int total = 0, bad = 0;
  int cycles = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_cmd(int k, int p);
    int j;
    if (k == p) return 4'b0010;
    if (k == p + T_RP) return 4'b0000;
    j = k - (p + T_RP + T_RSC);
    if (j >= 0 && j % T_RC == 0 && j / T_RC < N_REF) return 4'b0001;
    return 4'b0111;
  endfunction

  function automatic string tag_of(int k, int p);
    int c;
    c = exp_cmd(k, p);
    if (k < p) return "R2";
    if (c == 4'b0010) return "R3";
    if (c == 4'b0000) return "R4";
    if (c == 4'b0001) return (k == p + T_RP + T_RSC) ? "R5" : "R6";
    return "R9";
  endfunction

  task automatic cmp(int k, int p, logic cs, logic ras, logic cas, logic we,
                     logic ck, logic [1:0] dm, logic [12:0] ad, logic dn);
    int c, ea;
    c = exp_cmd(k, p);
    ea = (c == 4'b0010) ? 13'h0400 : (c == 4'b0000) ? int'(MODE) : 0;
    chk({tag_of(k, p), " cmd"}, {cs, ras, cas, we}, c);
    chk({tag_of(k, p), " addr"}, ad, ea);
    chk("R7 done", dn, (k >= p + T_RP + T_RSC + N_REF * T_RC) ? 1 : 0);
    chk("R8 cke/dqm", {ck, dm}, 3'b111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset cmd", {a_cs, a_ras, a_cas, a_we}, 4'b0111);
    chk("R1 reset addr", a_addr, 0);
    chk("R1 reset done", a_done, 0);
    chk("R1 reset cke/dqm", {a_cke, a_dqm}, 3'b111);
    @(negedge clk);
    rst = 0;
    #1;
    for (int k = 0; k < RUN; k++) begin
      cmp(k, P_MAIN, a_cs, a_ras, a_cas, a_we, a_cke, a_dqm, a_addr, a_done);
      cmp(k, P_CEIL, b_cs, b_ras, b_cas, b_we, b_cke, b_dqm, b_addr, b_done);
      @(negedge clk);
      #1;
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule